// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends asynchronous serial frames on a single output line. The host writes a byte, plus an optional ninth bit, into a one-entry holding register. A shift register behind it serialises one frame at a time. Because of this double buffering, the host can queue the next byte while the current frame is still on the line. The shifter takes the queued byte only after the previous frame's stop bit has completed.

A reloadable down-counter divides the system clock to produce a bit-clock tick. The counter reloads from the low 8 bits or from all 16 bits of the reload input. Each bit lasts either 16 or 64 ticks.

A holding-register-empty flag tells the host when it may write again, and an interrupt line is that flag gated by an enable. A separate shifter-empty status shows that the line is quiet. Dropping the transmit enable abandons everything in flight.

Top module: `sertx_top`

## Requirements
- R1: A frame is one low start bit, then 8 data bits (9 when `nine_bit_i` is 1), then one high stop bit, with no parity bit.
- R2: Data bits leave least significant first. The ninth bit is the `wbit9_i` value captured with the write, and it is sent after bit 7.
- R3: The shifter loads from the holding register only while it is idle and the holding register is full. A byte queued during a frame therefore starts its start bit one clock after the previous stop bit ends.
- R4: `hold_empty_o` rises one clock after the holding register hands its contents to the shifter. Only a host write or a disable lowers it.
- R5: Raising `tx_en_i` while the holding register is empty makes `hold_empty_o` high from the second clock edge that sees the enable onward.
- R6: After a write sampled at edge k, `hold_empty_o` is low once edge k+1 has passed. Its value between edges k and k+1 is unspecified.
- R7: `irq_o` is high exactly when `hold_empty_o` and `irq_en_i` are both high. `hold_empty_o` does not depend on `irq_en_i`.
- R8: `shift_empty_o` is high whenever no frame is being shifted, and it drives no interrupt.
- R9: A tick occurs every reload+1 clocks. With `wide_cnt_i`=0, only `reload_i[7:0]` is used. A bit lasts 16 ticks when `fast_tick_i`=1 and 64 ticks when it is 0.
- R10: A new `reload_i` value is used at the next terminal count, not earlier.
- R11: With `tx_en_i` low, a frame in progress is aborted, the holding register is emptied, `hold_empty_o` is low, and host writes are ignored.
- R12: `txd_o` is high whenever no frame is in progress, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmit enable |
| nine_bit_i | input | 1 | 1 selects 9 data bits |
| wide_cnt_i | input | 1 | 1 selects a 16-bit reload, 0 selects an 8-bit reload |
| fast_tick_i | input | 1 | 1 gives 16 ticks per bit, 0 gives 64 |
| reload_i | input | 16 | Baud counter reload value |
| wr_i | input | 1 | Holding register write strobe |
| wdata_i | input | 8 | Write data |
| wbit9_i | input | 1 | Ninth data bit, captured with the write |
| irq_en_i | input | 1 | Interrupt enable |
| hold_empty_o | output | 1 | Holding register empty flag |
| irq_o | output | 1 | Interrupt request |
| shift_empty_o | output | 1 | Shifter idle status |
| txd_o | output | 1 | Serial output |

## Verification
A write is visible in the empty flag only after the second clock edge, whereas a handoff raises the flag one edge after the shifter loads. A loaded frame drives its start bit right after the load edge, and each further line change comes (reload+1) × 16 or × 64 clocks later. The bench keeps a behavioural model that advances on the same edge the design samples. The model is compared 2 ns after every rising edge, so every output is checked in the cycle it is due. Directed checks for the write-to-flag delay, the disable behaviour and the interrupt gating sample at the same edge-relative point.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int SUB_W = 6;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_state_e;

    // last sub-bit count of a bit period: 16 or 64 ticks
    function automatic logic [SUB_W-1:0] last_sub(input logic fast);
        return fast ? SUB_W'(15) : SUB_W'(63);
    endfunction
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wide,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);
    localparam logic [CNT_W-1:0] NARROW_MASK =
        {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } baud_st_t;

    baud_st_t         s_d, s_q;
    logic [CNT_W-1:0] reload_eff;

    always_comb begin
        reload_eff = wide ? reload : (reload & NARROW_MASK);
        tick       = run && (s_q.cnt == '0);
        s_d        = s_q;
        if (!run || (s_q.cnt == '0)) begin
            s_d.cnt = reload_eff;
        end else begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wbit9,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              bit9,
    output logic              empty_flag
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              flag;
    } hold_st_t;

    hold_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        // the flag trails the buffer state by one register
        s_d.flag = run && !s_q.full;
        if (!run) begin
            s_d.full = 1'b0;
        end else if (wr) begin
            s_d.full = 1'b1;
            s_d.data = wdata;
            s_d.bit9 = wbit9;
        end else if (take) begin
            s_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign full       = s_q.full;
    assign data       = s_q.data;
    assign bit9       = s_q.bit9;
    assign empty_flag = s_q.flag;
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              nine,
    input  logic              fast,
    input  logic              tick,
    input  logic              full,
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    output logic              take,
    output logic              txd,
    output logic              idle
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int LEFT_W  = $clog2(FRAME_W + 1);

    typedef struct packed {
        sh_state_e          state;
        logic [FRAME_W-1:0] frame;
        logic [LEFT_W-1:0]  left;
        logic [SUB_W-1:0]   sub;
    } shift_st_t;

    shift_st_t s_d, s_q;

    always_comb begin
        take = run && (s_q.state == SH_IDLE) && full;
        s_d  = s_q;
        if (!run) begin
            s_d.state = SH_IDLE;
            s_d.frame = '1;
            s_d.left  = '0;
            s_d.sub   = '0;
        end else if (s_q.state == SH_BUSY) begin
            if (tick) begin
                if (s_q.sub == last_sub(fast)) begin
                    s_d.sub   = '0;
                    s_d.frame = {1'b1, s_q.frame[FRAME_W-1:1]};
                    s_d.left  = s_q.left - LEFT_W'(1);
                    if (s_q.left == LEFT_W'(1)) begin
                        s_d.state = SH_IDLE;
                    end
                end else begin
                    s_d.sub = s_q.sub + SUB_W'(1);
                end
            end
        end else if (take) begin
            s_d.state = SH_BUSY;
            s_d.frame = {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
            s_d.left  = nine ? LEFT_W'(FRAME_W) : LEFT_W'(FRAME_W - 1);
            s_d.sub   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= SH_IDLE;
            s_q.frame <= '1;
            s_q.left  <= '0;
            s_q.sub   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd  = (s_q.state == SH_BUSY) ? s_q.frame[0] : 1'b1;
    assign idle = (s_q.state == SH_IDLE);
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_i,
    input  logic              nine_bit_i,
    input  logic              wide_cnt_i,
    input  logic              fast_tick_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wbit9_i,
    input  logic              irq_en_i,
    output logic              hold_empty_o,
    output logic              irq_o,
    output logic              shift_empty_o,
    output logic              txd_o
);
    localparam int NARROW_W = CNT_W / 2;

    logic              tick;
    logic              take;
    logic              full;
    logic [DATA_W-1:0] hdata;
    logic              hbit9;
    logic              flag;

    sertx_baud #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tx_en_i),
        .wide   (wide_cnt_i),
        .reload (reload_i),
        .tick   (tick)
    );

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (tx_en_i),
        .wr         (wr_i),
        .wdata      (wdata_i),
        .wbit9      (wbit9_i),
        .take       (take),
        .full       (full),
        .data       (hdata),
        .bit9       (hbit9),
        .empty_flag (flag)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tx_en_i),
        .nine  (nine_bit_i),
        .fast  (fast_tick_i),
        .tick  (tick),
        .full  (full),
        .data  (hdata),
        .bit9  (hbit9),
        .take  (take),
        .txd   (txd_o),
        .idle  (shift_empty_o)
    );

    assign hold_empty_o = flag;
    assign irq_o        = flag & irq_en_i;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en_i,
    input logic wr_i,
    input logic irq_en_i,
    input logic hold_empty_o,
    input logic irq_o,
    input logic shift_empty_o,
    input logic txd_o
);
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty_o) |-> !txd_o); // R1

    AST_LOAD_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(shift_empty_o) && $past(tx_en_i)) |-> $past(txd_o)); // R3

    AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_i && wr_i) |=> ##1 !hold_empty_o); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (hold_empty_o && irq_en_i)); // R7

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_i |=> (txd_o && shift_empty_o && !hold_empty_o)); // R11

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty_o |-> txd_o); // R12
endmodule

bind sertx_top sertx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_en_i       (tx_en_i),
    .wr_i          (wr_i),
    .irq_en_i      (irq_en_i),
    .hold_empty_o  (hold_empty_o),
    .irq_o         (irq_o),
    .shift_empty_o (shift_empty_o),
    .txd_o         (txd_o)
);

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en_i = 1'b0;
    logic        nine_bit_i = 1'b0;
    logic        wide_cnt_i = 1'b0;
    logic        fast_tick_i = 1'b1;
    logic [15:0] reload_i = 16'h0302;
    logic        wr_i = 1'b0;
    logic [7:0]  wdata_i = 8'h00;
    logic        wbit9_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic        hold_empty_o, irq_o, shift_empty_o, txd_o;

    always #2.5 clk = ~clk;

    sertx_top u0 (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en_i), .nine_bit_i(nine_bit_i),
        .wide_cnt_i(wide_cnt_i), .fast_tick_i(fast_tick_i), .reload_i(reload_i),
        .wr_i(wr_i), .wdata_i(wdata_i), .wbit9_i(wbit9_i), .irq_en_i(irq_en_i),
        .hold_empty_o(hold_empty_o), .irq_o(irq_o),
        .shift_empty_o(shift_empty_o), .txd_o(txd_o)
    );

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    // behavioural reference model
    int m_cnt = 0;
    int m_sub = 0;
    int m_data = 0;
    bit m_full = 0, m_flag = 0, m_active = 0, m_b9 = 0;
    bit m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_sub = 0; m_full = 0; m_flag = 0; m_active = 0;
            m_q.delete();
        end else begin
            int  reff;
            int  last;
            bit  tick, load, nflag;
            reff  = wide_cnt_i ? int'(reload_i) : int'(reload_i[7:0]);
            last  = fast_tick_i ? 15 : 63;
            tick  = tx_en_i && (m_cnt == 0);
            load  = tx_en_i && !m_active && m_full;
            if (!tx_en_i) begin
                m_active = 0; m_sub = 0; m_q.delete();
            end else if (m_active) begin
                if (tick) begin
                    if (m_sub == last) begin
                        m_sub = 0;
                        void'(m_q.pop_front());
                        if (m_q.size() == 0) m_active = 0;
                    end else begin
                        m_sub++;
                    end
                end
            end else if (load) begin
                m_q.delete();
                m_q.push_back(1'b0);
                for (int i = 0; i < 8; i++) m_q.push_back(m_data[i]);
                if (nine_bit_i) m_q.push_back(m_b9);
                m_q.push_back(1'b1);
                m_active = 1; m_sub = 0;
            end
            nflag = tx_en_i && !m_full;
            if (!tx_en_i) m_full = 0;
            else if (wr_i) begin
                m_full = 1; m_data = int'(wdata_i); m_b9 = wbit9_i;
            end else if (load) m_full = 0;
            m_flag = nflag;
            m_cnt  = (!tx_en_i || m_cnt == 0) ? reff : m_cnt - 1;
        end
    end

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     req, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (!done) begin
            check("R1 R2 R9 R10 R12", "txd", int'(txd_o),
                  m_active ? int'(m_q[0]) : 1);
            check("R4 R5 R6 R11", "hold_empty", int'(hold_empty_o), int'(m_flag));
            check("R7", "irq", int'(irq_o), int'(m_flag && irq_en_i));
            check("R3 R8", "shift_empty", int'(shift_empty_o), int'(!m_active));
        end
    end

    task automatic report();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            report();
        end
    end

    task automatic write(input logic [7:0] d, input logic b9);
        @(negedge clk);
        wr_i = 1'b1; wdata_i = d; wbit9_i = b9;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (shift_empty_o && hold_empty_o) break;
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        check("R12", "txd in reset", int'(txd_o), 1);
        check("R8", "shift_empty in reset", int'(shift_empty_o), 1);
        check("R4", "hold_empty in reset", int'(hold_empty_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R5: enable sets the flag
        irq_en_i = 1'b1;
        tx_en_i  = 1'b1;
        repeat (3) @(negedge clk);
        check("R5", "flag after enable", int'(hold_empty_o), 1);
        check("R7", "irq after enable", int'(irq_o), 1);
        // R6: flag low once the edge after the write edge has passed
        @(negedge clk);
        wr_i = 1'b1; wdata_i = 8'hA5; wbit9_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        wr_i = 1'b0;
        @(posedge clk); #2;
        check("R6", "flag after write", int'(hold_empty_o), 0);
        // R3: queue a second byte behind the first
        write(8'h3C, 1'b0);
        wait_idle();
        // R1 R2: nine-bit frames
        nine_bit_i = 1'b1;
        write(8'h5A, 1'b1);
        write(8'h0F, 1'b0);
        wait_idle();
        // R9: 64 ticks per bit
        nine_bit_i = 1'b0; fast_tick_i = 1'b0;
        write(8'hC3, 1'b0);
        wait_idle();
        // R9 R10: wide counter, reload changed mid-frame
        fast_tick_i = 1'b1; wide_cnt_i = 1'b1; reload_i = 16'h0004;
        write(8'h81, 1'b0);
        repeat (200) @(negedge clk);
        reload_i = 16'h0001;
        wait_idle();
        // R7: interrupt masked while flag set
        irq_en_i = 1'b0;
        @(negedge clk);
        check("R7", "irq masked", int'(irq_o), 0);
        check("R7", "flag unaffected by mask", int'(hold_empty_o), 1);
        irq_en_i = 1'b1;
        // R11: writes while disabled are ignored
        tx_en_i = 1'b0;
        write(8'h77, 1'b0);
        tx_en_i = 1'b1;
        repeat (4) @(negedge clk);
        check("R11", "no frame after ignored write", int'(shift_empty_o), 1);
        check("R11", "flag after ignored write", int'(hold_empty_o), 1);
        // R11: abort mid-frame
        write(8'h00, 1'b0);
        repeat (30) @(negedge clk);
        check("R11", "frame running before abort", int'(shift_empty_o), 0);
        tx_en_i = 1'b0;
        @(posedge clk); #2;
        check("R11", "txd after abort", int'(txd_o), 1);
        check("R11", "shift_empty after abort", int'(shift_empty_o), 1);
        check("R11", "flag while disabled", int'(hold_empty_o), 0);
        repeat (5) @(negedge clk);
        report();
    end
endmodule